// File: doc/BRIEF.md
# Spare Area ECC Packer and Checker

This block sits between a NAND page transfer path and an external ECC engine and owns the 64-byte spare region of each page. On a read it takes the spare bytes as they arrive and tags each one as metadata, main-data parity or metadata parity. It keeps the metadata and counts bytes that are not 0xFF. It then runs the engine twice, main data first and metadata second, and packs the two verdicts and an erased-page flag into one result code. The metadata goes back to the host, or all 0xFF when its own check cannot correct it.

On a write it takes twelve metadata bytes from the host, or all 0xFF when the host has none. It runs the same two engine steps in encode mode, keeps the parity bytes the engine returns, and then emits the finished 64-byte spare image. Both directions feed the engine a 512-byte block for the metadata step: the metadata followed by 0xFF filler. A cycle counter bounds every wait on the engine. When it expires the operation ends early with an error bit set.

Top module: `spare_ecc_unit`

## Requirements
- R1: During read capture each accepted spare byte appears on `fld_byte` in the same cycle with `fld_valid` high and `fld_id` = 0 for byte positions 0–11, 1 for positions 12–51 and 2 for positions 52–63.
- R2: `sp_empty` is cleared when an operation starts. In the cycle after the 64th read byte is accepted, it becomes 1 exactly when fewer than 2 of the 64 bytes differ from 0xFF.
- R3: On a read, `res_code` at `op_done` holds the empty flag in bit 1, the main-data engine verdict in bits 7:4 and the metadata engine verdict in bits 11:8. Bits 3:2 are zero.
- R4: At `op_done` of a read, `meta_out` carries spare bytes 0–11, with byte i in bits 8i+7:8i. If bit 0 of the metadata verdict is set, every bit of `meta_out` is 1 instead.
- R5: Before the metadata engine step, in either direction, `pad_valid` carries exactly 512 bytes: the 12 metadata bytes in order, then 500 bytes of 0xFF.
- R6: Each operation starts the engine with one-cycle `eng_start` pulses: first `eng_kind`=0 (main data), then `eng_kind`=1 (metadata). `eng_encode` is 1 on writes and 0 on reads.
- R7: A write emits 64 bytes on `sp_out_valid` only after both encode steps complete. Positions 0–11 hold the metadata, 12–51 hold the 40 main-data parity bytes in arrival order, and 52–63 hold the 12 metadata parity bytes.
- R8: A write started with `wr_has_spare`=0 uses 0xFF for all twelve metadata bytes, both in the padded block and in the spare image.
- R9: If `eng_done` does not arrive within `TMO_CYC` cycles of an engine step, the operation ends at once. `res_code` bit 0 is set, the later steps do not run, no spare image is emitted, and `meta_out` on a read is all ones.
- R10: Spare input bytes presented outside a read capture are ignored: `fld_valid` stays low and the next read's empty flag is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_rd | input | 1 | Begin a read operation (sampled when idle) |
| start_wr | input | 1 | Begin a write operation (sampled when idle) |
| wr_has_spare | input | 1 | Host supplies metadata on this write |
| host_meta | input | 96 | Host metadata, byte i at bits 8i+7:8i |
| sp_in_valid | input | 1 | Incoming spare byte strobe |
| sp_in_byte | input | 8 | Incoming spare byte |
| fld_valid | output | 1 | Classified read byte strobe |
| fld_id | output | 2 | Field of the read byte: 0 metadata, 1 data parity, 2 metadata parity |
| fld_byte | output | 8 | Classified read byte |
| sp_empty | output | 1 | Erased-page flag |
| eng_start | output | 1 | Engine step start pulse |
| eng_kind | output | 1 | Engine step: 0 main data, 1 metadata |
| eng_encode | output | 1 | Engine mode: 1 encode, 0 decode |
| eng_done | input | 1 | Engine step finished |
| eng_result | input | 4 | Engine verdict, bit 0 = uncorrectable |
| eng_par_valid | input | 1 | Engine parity byte strobe (encode) |
| eng_par_byte | input | 8 | Engine parity byte |
| pad_valid | output | 1 | Padded metadata block strobe |
| pad_byte | output | 8 | Padded metadata block byte |
| sp_out_valid | output | 1 | Outgoing spare image strobe |
| sp_out_byte | output | 8 | Outgoing spare image byte |
| op_done | output | 1 | Operation complete pulse |
| res_code | output | 12 | Result code |
| meta_out | output | 96 | Metadata delivered to the host |

## Verification
A wrong byte position counter shows up in the same cycle as a wrong `fld_id` on the read stream, and later as a metadata byte or parity byte moved within the written image. A stale or wrongly updated non-0xFF count shows at the edge one cycle after the last read byte, as a wrong `sp_empty`. A sequencer that skips or reorders a step shows as a missing `eng_start`, a padded block of the wrong length, or an early `op_done`. A verdict stored in the wrong register is visible only at `op_done`, as misplaced `res_code` nibbles or missing metadata masking.

// File: rtl/spare_pkg.sv
// Shared types for the spare area packer/checker.
// Assumes: a single sequencer state type and fixed field codes seen at the ports.
package spare_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RD_IN,
        S_D_GO,
        S_D_WAIT,
        S_PAD,
        S_M_GO,
        S_M_WAIT,
        S_WR_OUT,
        S_FIN
    } seq_state_t;

    localparam logic [1:0] FLD_META = 2'd0;
    localparam logic [1:0] FLD_DECC = 2'd1;
    localparam logic [1:0] FLD_MECC = 2'd2;

endpackage

// File: rtl/spare_erase_census.sv
// Counts spare bytes and the bytes among them that are not 0xFF, and raises
// the erased-page flag one cycle after the final byte of the window.
// Assumes: the caller clears it before each window and feeds at most
// SPARE_BYTES strobes between clears.
module spare_erase_census #(
    parameter int SPARE_BYTES = 64,
    parameter int EMPTY_LIMIT = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       byte_valid,
    input  logic [7:0] byte_in,
    output logic       empty_q
);
    localparam int CW = $clog2(SPARE_BYTES + 1);

    logic [CW-1:0] seen_q;
    logic [CW-1:0] dirty_q;
    logic [CW-1:0] dirty_nx;

    // Running count of non-0xFF bytes including the current one.
    always_comb begin
        dirty_nx = dirty_q + CW'((byte_valid && byte_in != 8'hFF) ? 1 : 0);
    end

    // Window counters and the flag, updated on the last byte of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= '0;
            dirty_q <= '0;
            empty_q <= 1'b0;
        end else if (clear) begin
            seen_q  <= '0;
            dirty_q <= '0;
            empty_q <= 1'b0;
        end else if (byte_valid) begin
            seen_q  <= seen_q + 1'b1;
            dirty_q <= dirty_nx;
            if (seen_q == CW'(SPARE_BYTES - 1))
                empty_q <= (dirty_nx < CW'(EMPTY_LIMIT));
        end
    end

    // R2
    dirty_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dirty_q <= seen_q);

endmodule

// File: rtl/spare_wait_timer.sv
// Bounds a wait on the ECC engine: counts cycles while running and flags
// expiry when LIMIT cycles have passed since the last clear.
// Assumes: clear is pulsed before each wait.
module spare_wait_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    output logic expired
);
    localparam int TW = $clog2(LIMIT + 1);

    logic [TW-1:0] cnt_q;

    assign expired = (cnt_q == TW'(LIMIT));

    // Cycle counter that saturates at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                cnt_q <= '0;
        else if (clear)            cnt_q <= '0;
        else if (run && !expired)  cnt_q <= cnt_q + 1'b1;
    end

    // R9
    expiry_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(expired) |-> $past(run));

endmodule

// File: rtl/spare_pad_stream.sv
// Streams the padded metadata block: the metadata bytes in order followed by
// 0xFF filler up to PAD_BYTES bytes, one byte per cycle after a start pulse.
// Assumes: meta_in is stable while streaming; start is not repeated mid-stream.
module spare_pad_stream #(
    parameter int META_BYTES = 12,
    parameter int PAD_BYTES  = 512
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [META_BYTES*8-1:0] meta_in,
    output logic                    pad_valid,
    output logic [7:0]              pad_byte,
    output logic                    pad_last
);
    localparam int PW = $clog2(PAD_BYTES);

    logic          active_q;
    logic [PW-1:0] idx_q;

    assign pad_valid = active_q;
    assign pad_last  = active_q && (idx_q == PW'(PAD_BYTES - 1));

    // Select a metadata byte while in the head of the block, filler after it.
    always_comb begin
        pad_byte = 8'hFF;
        for (int i = 0; i < META_BYTES; i++)
            if (idx_q == PW'(i)) pad_byte = meta_in[i*8 +: 8];
    end

    // Position counter for the stream.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q) begin
            idx_q <= idx_q + 1'b1;
            if (pad_last) active_q <= 1'b0;
        end
    end

    // R5
    pad_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_last |=> !pad_valid);

endmodule

// File: rtl/spare_ecc_unit.sv
// Spare area packer/checker. Read: classifies 64 incoming spare bytes, keeps
// the metadata, runs data then metadata decode on the engine, and reports a
// result code plus (possibly masked) metadata. Write: runs data then metadata
// encode, keeps returned parity and emits the 64-byte spare image.
// Assumes: the engine returns parity bytes (encode) before raising eng_done,
// main-data parity first; start_rd/start_wr are only honoured when idle.
module spare_ecc_unit import spare_pkg::*; #(
    parameter int META_BYTES  = 12,
    parameter int DECC_BYTES  = 40,
    parameter int MECC_BYTES  = 12,
    parameter int PAD_BYTES   = 512,
    parameter int EMPTY_LIMIT = 2,
    parameter int TMO_CYC     = 1000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start_rd,
    input  logic                    start_wr,
    input  logic                    wr_has_spare,
    input  logic [META_BYTES*8-1:0] host_meta,
    input  logic                    sp_in_valid,
    input  logic [7:0]              sp_in_byte,
    output logic                    fld_valid,
    output logic [1:0]              fld_id,
    output logic [7:0]              fld_byte,
    output logic                    sp_empty,
    output logic                    eng_start,
    output logic                    eng_kind,
    output logic                    eng_encode,
    input  logic                    eng_done,
    input  logic [3:0]              eng_result,
    input  logic                    eng_par_valid,
    input  logic [7:0]              eng_par_byte,
    output logic                    pad_valid,
    output logic [7:0]              pad_byte,
    output logic                    sp_out_valid,
    output logic [7:0]              sp_out_byte,
    output logic                    op_done,
    output logic [11:0]             res_code,
    output logic [META_BYTES*8-1:0] meta_out
);
    localparam int SPARE_BYTES = META_BYTES + DECC_BYTES + MECC_BYTES;
    localparam int PAR_BYTES   = DECC_BYTES + MECC_BYTES;
    localparam int BIW         = $clog2(SPARE_BYTES);
    localparam int PAW         = $clog2(PAR_BYTES + 1);
    localparam int MBW         = META_BYTES * 8;

    seq_state_t     state_q;
    logic           rd_op_q;
    logic [MBW-1:0] meta_q;
    logic [7:0]     par_buf [PAR_BYTES];
    logic [PAW-1:0] par_idx_q;
    logic [PAW-1:0] par_rd;
    logic [BIW-1:0] byte_idx_q;
    logic [3:0]     dnib_q;
    logic [3:0]     mnib_q;
    logic           err_q;
    logic           in_wait;
    logic           par_wr;
    logic           tmr_expired;
    logic           pad_start;
    logic           pad_last;
    logic           op_begin;

    assign op_begin  = (state_q == S_IDLE) && (start_rd || start_wr);
    assign in_wait   = (state_q == S_D_WAIT) || (state_q == S_M_WAIT);
    assign par_wr    = in_wait && !rd_op_q && eng_par_valid && (par_idx_q < PAW'(PAR_BYTES));
    assign pad_start = (state_q == S_D_WAIT) && eng_done;

    // Port-facing strobes and codes derived from the sequencer state.
    always_comb begin
        fld_valid    = (state_q == S_RD_IN) && sp_in_valid;
        fld_byte     = sp_in_byte;
        if (byte_idx_q < BIW'(META_BYTES))                   fld_id = FLD_META;
        else if (byte_idx_q < BIW'(META_BYTES + DECC_BYTES)) fld_id = FLD_DECC;
        else                                                 fld_id = FLD_MECC;
        eng_start    = (state_q == S_D_GO) || (state_q == S_M_GO);
        eng_kind     = (state_q == S_M_GO) || (state_q == S_M_WAIT);
        eng_encode   = !rd_op_q;
        sp_out_valid = (state_q == S_WR_OUT);
        op_done      = (state_q == S_FIN);
        res_code     = {mnib_q, dnib_q, 2'b00, rd_op_q & sp_empty, err_q};
        meta_out     = (rd_op_q && (mnib_q[0] || err_q)) ? {MBW{1'b1}} : meta_q;
    end

    // Outgoing spare image byte: metadata head, then stored parity.
    always_comb begin
        par_rd      = PAW'(byte_idx_q - BIW'(META_BYTES));
        sp_out_byte = par_buf[par_rd];
        for (int i = 0; i < META_BYTES; i++)
            if (byte_idx_q == BIW'(i)) sp_out_byte = meta_q[i*8 +: 8];
    end

    // Parity storage (data array, no reset needed).
    always_ff @(posedge clk) begin
        if (par_wr) par_buf[par_idx_q] <= eng_par_byte;
    end

    // Operation sequencer: capture, data step, pad, metadata step, output.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            rd_op_q    <= 1'b0;
            meta_q     <= '0;
            par_idx_q  <= '0;
            byte_idx_q <= '0;
            dnib_q     <= '0;
            mnib_q     <= '0;
            err_q      <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (op_begin) begin
                        rd_op_q    <= start_rd;
                        byte_idx_q <= '0;
                        dnib_q     <= '0;
                        mnib_q     <= '0;
                        err_q      <= 1'b0;
                        if (start_rd) begin
                            state_q <= S_RD_IN;
                        end else begin
                            meta_q  <= wr_has_spare ? host_meta : {MBW{1'b1}};
                            state_q <= S_D_GO;
                        end
                    end
                end
                S_RD_IN: begin
                    if (sp_in_valid) begin
                        for (int i = 0; i < META_BYTES; i++)
                            if (byte_idx_q == BIW'(i)) meta_q[i*8 +: 8] <= sp_in_byte;
                        byte_idx_q <= byte_idx_q + 1'b1;
                        if (byte_idx_q == BIW'(SPARE_BYTES - 1)) state_q <= S_D_GO;
                    end
                end
                S_D_GO: begin
                    par_idx_q <= '0;
                    state_q   <= S_D_WAIT;
                end
                S_D_WAIT: begin
                    if (par_wr) par_idx_q <= par_idx_q + 1'b1;
                    if (eng_done) begin
                        if (rd_op_q) dnib_q <= eng_result;
                        state_q <= S_PAD;
                    end else if (tmr_expired) begin
                        err_q   <= 1'b1;
                        state_q <= S_FIN;
                    end
                end
                S_PAD: begin
                    if (pad_last) state_q <= S_M_GO;
                end
                S_M_GO: begin
                    par_idx_q <= PAW'(DECC_BYTES);
                    state_q   <= S_M_WAIT;
                end
                S_M_WAIT: begin
                    if (par_wr) par_idx_q <= par_idx_q + 1'b1;
                    if (eng_done) begin
                        if (rd_op_q) mnib_q <= eng_result;
                        byte_idx_q <= '0;
                        state_q    <= rd_op_q ? S_FIN : S_WR_OUT;
                    end else if (tmr_expired) begin
                        err_q   <= 1'b1;
                        state_q <= S_FIN;
                    end
                end
                S_WR_OUT: begin
                    byte_idx_q <= byte_idx_q + 1'b1;
                    if (byte_idx_q == BIW'(SPARE_BYTES - 1)) state_q <= S_FIN;
                end
                S_FIN:   state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    spare_erase_census #(
        .SPARE_BYTES (SPARE_BYTES),
        .EMPTY_LIMIT (EMPTY_LIMIT)
    ) u_census (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (op_begin),
        .byte_valid (fld_valid),
        .byte_in    (sp_in_byte),
        .empty_q    (sp_empty)
    );

    spare_wait_timer #(
        .LIMIT (TMO_CYC)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (eng_start),
        .run     (in_wait),
        .expired (tmr_expired)
    );

    spare_pad_stream #(
        .META_BYTES (META_BYTES),
        .PAD_BYTES  (PAD_BYTES)
    ) u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (pad_start),
        .meta_in   (meta_q),
        .pad_valid (pad_valid),
        .pad_byte  (pad_byte),
        .pad_last  (pad_last)
    );

    // R6
    eng_go_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |=> !eng_start);

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_done |=> !op_done);

    // R1
    stream_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(fld_valid && sp_out_valid));

    // R4
    meta_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op_done && res_code[8]) |-> (meta_out == {MBW{1'b1}}));

    // R7
    image_after_encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sp_out_valid) |-> $past(eng_done));

endmodule

// File: tb/spare_ecc_unit_tb.sv
module spare_ecc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_rd = 1'b0, start_wr = 1'b0, wr_has_spare = 1'b0;
    logic [95:0] host_meta = '0;
    logic        sp_in_valid = 1'b0;
    logic [7:0]  sp_in_byte = 8'h00;
    logic        fld_valid;
    logic [1:0]  fld_id;
    logic [7:0]  fld_byte;
    logic        sp_empty;
    logic        eng_start, eng_kind, eng_encode;
    logic        eng_done, eng_par_valid;
    logic [3:0]  eng_result;
    logic [7:0]  eng_par_byte;
    logic        pad_valid, sp_out_valid, op_done;
    logic [7:0]  pad_byte, sp_out_byte;
    logic [11:0] res_code;
    logic [95:0] meta_out;

    always #4 clk = ~clk;

    spare_ecc_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start_rd(start_rd), .start_wr(start_wr),
        .wr_has_spare(wr_has_spare), .host_meta(host_meta),
        .sp_in_valid(sp_in_valid), .sp_in_byte(sp_in_byte),
        .fld_valid(fld_valid), .fld_id(fld_id), .fld_byte(fld_byte),
        .sp_empty(sp_empty), .eng_start(eng_start), .eng_kind(eng_kind),
        .eng_encode(eng_encode), .eng_done(eng_done), .eng_result(eng_result),
        .eng_par_valid(eng_par_valid), .eng_par_byte(eng_par_byte),
        .pad_valid(pad_valid), .pad_byte(pad_byte),
        .sp_out_valid(sp_out_valid), .sp_out_byte(sp_out_byte),
        .op_done(op_done), .res_code(res_code), .meta_out(meta_out)
    );

    int total = 0, bad = 0;
    logic [7:0]  sp [64];
    logic [7:0]  got_out [64];
    int          n_out, n_pad, pad_bad;
    logic [11:0] got_res;
    logic [95:0] got_meta;
    logic [3:0]  e_dres = 0, e_mres = 0;
    int          e_hang = 0;
    int          n_start = 0;
    logic        log_kind [4];
    logic        log_enc [4];
    logic        ek, ee;
    bit          hang_now;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // ECC engine model: parity bytes then done, or never done when hung.
    initial begin
        eng_done = 0; eng_result = 0; eng_par_valid = 0; eng_par_byte = 0;
        forever begin
            @(negedge clk);
            if (eng_start === 1'b1) begin
                ek = eng_kind; ee = eng_encode;
                if (n_start < 4) begin log_kind[n_start] = ek; log_enc[n_start] = ee; end
                n_start++;
                hang_now = (e_hang == 1 && !ek) || (e_hang == 2 && ek);
                if (!hang_now) begin
                    repeat (2) @(negedge clk);
                    if (ee) for (int j = 0; j < (ek ? 12 : 40); j++) begin
                        eng_par_valid = 1;
                        eng_par_byte  = ek ? 8'(8'hC0 + j) : 8'(8'h30 + j);
                        @(negedge clk);
                    end
                    eng_par_valid = 0;
                    eng_result = ek ? e_mres : e_dres;
                    eng_done = 1;
                    @(negedge clk);
                    eng_done = 0;
                end
            end
        end
    end

    task automatic run_until_done(input logic [95:0] pm);
        n_pad = 0; pad_bad = 0; n_out = 0;
        for (int c = 0; c < 5000; c++) begin
            @(negedge clk); #1;
            if (pad_valid) begin
                if (n_pad < 512 && pad_byte !== ((n_pad < 12) ? pm[n_pad*8 +: 8] : 8'hFF)) pad_bad++;
                n_pad++;
            end
            if (sp_out_valid) begin
                if (n_out < 64) got_out[n_out] = sp_out_byte;
                n_out++;
            end
            if (op_done) begin
                got_res = res_code; got_meta = meta_out;
                break;
            end
        end
    endtask

    task automatic do_read(input logic [3:0] dres, input logic [3:0] mres, input int hang);
        logic [95:0] pm;
        logic [95:0] exp_meta;
        logic [11:0] exp_res;
        int nd, fb;
        logic [1:0] exp_id;
        bit exp_empty;
        e_dres = dres; e_mres = mres; e_hang = hang; n_start = 0;
        nd = 0;
        for (int i = 0; i < 64; i++) if (sp[i] != 8'hFF) nd++;
        exp_empty = (nd < 2);
        for (int i = 0; i < 12; i++) pm[i*8 +: 8] = sp[i];
        @(negedge clk); start_rd = 1;
        @(negedge clk); start_rd = 0;
        fb = 0;
        for (int i = 0; i < 64; i++) begin
            sp_in_valid = 1; sp_in_byte = sp[i];
            #1;
            exp_id = (i < 12) ? 2'd0 : (i < 52) ? 2'd1 : 2'd2;
            if (!(fld_valid === 1'b1 && fld_id === exp_id && fld_byte === sp[i])) fb++;
            if (i == 63) chk(sp_empty === 1'b0, "R2", "flag before window end", 128'(sp_empty), 0);
            @(negedge clk);
        end
        sp_in_valid = 0;
        #1;
        chk(sp_empty === exp_empty, "R2", "empty flag", 128'(sp_empty), 128'(exp_empty));
        chk(fb == 0, "R1", "field classification mismatches", 128'(fb), 0);
        run_until_done(pm);
        if (hang == 1) begin
            exp_res = {8'h00, 2'b00, exp_empty, 1'b1};
            exp_meta = '1;
            chk(n_pad == 0 && n_start == 1, "R9", "steps after data timeout", 128'(n_pad), 0);
        end else if (hang == 2) begin
            exp_res = {4'h0, dres, 2'b00, exp_empty, 1'b1};
            exp_meta = '1;
            chk(n_pad == 512 && pad_bad == 0, "R5", "pad block on read", 128'(pad_bad), 0);
        end else begin
            exp_res = {mres, dres, 2'b00, exp_empty, 1'b0};
            exp_meta = mres[0] ? '1 : pm;
            chk(n_pad == 512 && pad_bad == 0, "R5", "pad block on read", 128'(n_pad), 512);
            chk(n_start == 2 && log_kind[0] == 0 && log_kind[1] == 1 && log_enc[0] == 0 && log_enc[1] == 0,
                "R6", "read engine step order", 128'(n_start), 2);
        end
        chk(got_res === exp_res, hang != 0 ? "R9" : "R3", "read result code", 128'(got_res), 128'(exp_res));
        chk(got_meta === exp_meta, hang != 0 ? "R9" : "R4", "read metadata", 128'(got_meta), 128'(exp_meta));
    endtask

    task automatic do_write(input bit has, input logic [95:0] hm, input int hang);
        logic [95:0] pm;
        logic [7:0] eb;
        int ob;
        e_hang = hang; n_start = 0;
        pm = has ? hm : '1;
        @(negedge clk); start_wr = 1; wr_has_spare = has; host_meta = hm;
        @(negedge clk); start_wr = 0;
        run_until_done(pm);
        if (hang != 0) begin
            chk(n_out == 0, "R9", "no image after timeout", 128'(n_out), 0);
            chk(got_res === 12'h001, "R9", "write timeout code", 128'(got_res), 1);
        end else begin
            ob = 0;
            for (int i = 0; i < 64; i++) begin
                eb = (i < 12) ? pm[i*8 +: 8] : (i < 52) ? 8'(8'h30 + i - 12) : 8'(8'hC0 + i - 52);
                if (got_out[i] !== eb) ob++;
            end
            chk(n_out == 64, "R7", "image length", 128'(n_out), 64);
            chk(ob == 0, has ? "R7" : "R8", "image byte mismatches", 128'(ob), 0);
            chk(n_pad == 512 && pad_bad == 0, has ? "R5" : "R8", "pad block on write", 128'(pad_bad), 0);
            chk(n_start == 2 && log_kind[0] == 0 && log_kind[1] == 1 && log_enc[0] == 1 && log_enc[1] == 1,
                "R6", "write engine step order", 128'(n_start), 2);
            chk(got_res === 12'h000, "R3", "write result code", 128'(got_res), 0);
        end
        chk(sp_empty === 1'b0, "R2", "flag cleared at start", 128'(sp_empty), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk(op_done === 0 && eng_start === 0 && sp_out_valid === 0 && pad_valid === 0
            && fld_valid === 0 && res_code === 0 && sp_empty === 0,
            "R6", "reset state", 128'(res_code), 0);
        @(negedge clk); rst_n = 1;

        // Single-byte and clean patterns over every position.
        for (int p = -1; p < 64; p++) begin
            for (int i = 0; i < 64; i++) sp[i] = 8'hFF;
            if (p >= 0) sp[p] = 8'(p) ^ 8'h5A;
            do_read(4'(p + 1), 4'((p + 1) * 3), 0);
        end

        // Stray bytes while idle are ignored (R10).
        begin
            int sb;
            sb = 0;
            for (int k = 0; k < 4; k++) begin
                @(negedge clk); sp_in_valid = 1; sp_in_byte = 8'h00; #1;
                if (fld_valid !== 1'b0) sb++;
            end
            @(negedge clk); sp_in_valid = 0;
            chk(sb == 0, "R10", "strobes on idle input", 128'(sb), 0);
            for (int i = 0; i < 64; i++) sp[i] = 8'hFF;
            do_read(4'h2, 4'h4, 0);
            chk(got_res[1] === 1'b1, "R10", "empty after stray bytes", 128'(got_res), 0);
        end

        // Two-byte patterns across field boundaries, and a dense page.
        for (int q = 0; q < 5; q++) begin
            int a, b;
            a = (q == 0) ? 0 : (q == 1) ? 11 : (q == 2) ? 51 : (q == 3) ? 5 : 62;
            b = (q == 0) ? 63 : (q == 1) ? 12 : (q == 2) ? 52 : (q == 3) ? 40 : 63;
            for (int i = 0; i < 64; i++) sp[i] = 8'hFF;
            sp[a] = 8'h00; sp[b] = 8'h7E;
            do_read(4'(q), 4'(q + 8), 0);
        end
        for (int i = 0; i < 64; i++) sp[i] = 8'(i * 7 + 1);
        do_read(4'h6, 4'hA, 0);
        do_read(4'h3, 4'h5, 0);

        // Write path.
        do_write(1'b1, 96'h0B0A0908_07060504_03020100, 0);
        do_write(1'b1, 96'hDEADBEEF_12345678_A5C3E1F0, 0);
        do_write(1'b0, 96'h11111111_22222222_33333333, 0);

        // Timeouts.
        for (int i = 0; i < 64; i++) sp[i] = 8'(i + 3);
        do_read(4'h2, 4'h0, 1);
        do_read(4'h8, 4'h0, 2);
        do_write(1'b1, 96'h1, 1);
        do_write(1'b1, 96'h2, 2);
        e_hang = 0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=hung exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule